// File: doc/BRIEF.md
# Non-blocking crosspoint switch with double-buffered routing

This block routes sixteen data inputs to sixteen data outputs. Each output has its own selector, so any output can take any input, and several outputs can take the same input at once. The selectors that drive the multiplexers form the active bank. New routing is never written into the active bank directly. It is first collected in a pending bank, and a configure strobe then moves the whole pending bank into the active bank.

Two writers feed the pending bank. The first is a single-port write: a source address and a destination address are taken when a load strobe falls. The second is a bulk write from a fast-configuration loader in the same clock domain. It replaces all sixteen pending selectors in one cycle. The load and configure strobes may arrive asynchronously. Each passes through a two-flop synchroniser and an edge detector before it acts.

Reset routes every output to input 0 and does not touch the pending bank. After reset, one configure strobe brings back the last programmed routing. A ready flag reports when a configure sequence has finished.

Top module: `xpoint_switch`

## Requirements
- R1: Output n (bits [n*DATA_W +: DATA_W] of dataOut) always carries the input that active selector n names. Any number of outputs may name the same input.
- R2: A falling edge on loadIn sets pending selector dstAddr to srcAddr. The pending bank changes at the second rising edge after the edge that first samples the fall. srcAddr and dstAddr are taken in that cycle.
- R3: bulkWr high at a rising edge loads every pending selector from bulkSel, with output n taking bits [4n+3:4n]. If a single-port write lands at the same edge, the single-port write wins for its destination.
- R4: A falling edge on cfgN copies the pending bank into the active bank at the second rising edge after the edge that first samples the fall. Nothing else changes the active bank while rstN is high.
- R5: When a single-port write and a configure land at the same edge, the write reaches the pending bank first and is part of the transfer.
- R6: While rstN is low, every output carries input 0, with no clock edge needed.
- R7: Reset leaves the pending bank unchanged. A configure strobe after reset restores the routing that was last programmed.
- R8: During a transfer, outputs whose selector keeps its value carry their input without interruption.
- R9: ready is low after reset. It goes low when a rising edge on loadIn is detected and when a falling edge on cfgN is detected. It goes high when a rising edge on cfgN is detected, unless a clearing event is detected in the same cycle. Detection uses the R2 and R4 latency.
- R10: Writes to the pending bank have no effect on the outputs until a configure strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadIn | input | 1 | Single-port load strobe; the write is taken on its falling edge |
| srcAddr | input | 4 | Source input for a single-port write |
| dstAddr | input | 4 | Destination output for a single-port write |
| cfgN | input | 1 | Configure strobe, active low |
| bulkWr | input | 1 | Synchronous strobe for a bulk pending write |
| bulkSel | input | 64 | Bulk selector vector; output n uses bits [4n+3:4n] |
| dataIn | input | 16 | Input port data, one DATA_W slice per port |
| dataOut | output | 16 | Output port data, one DATA_W slice per port |
| ready | output | 1 | High once a configure sequence has finished |

## Verification
A strobe on loadIn or cfgN changes the pending bank, the active bank or ready three rising edges after the falling clock edge at which the bench drives it: two synchroniser stages and one register. A bulk write takes effect at the very next edge. Reset routing is combinational from the asynchronous clear. The bench drives every input on a falling edge. It then samples outputs one time unit after the falling edge that follows the exact edge count. Where the count matters, it also samples one edge earlier to show that the result has not yet arrived. For selectors that do not change, it also samples right after the transfer edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Pulses from the control path to the routing datapath, each one clock wide
  typedef struct packed {
    logic portWr;    // single-port write into the pending bank
    logic cfgXfer;   // copy pending bank into the active bank
    logic readyClr;  // drive ready low
    logic readySet;  // drive ready high
  } xbar_strb_t;

endpackage

// File: rtl/xbar_sync.sv
module xbar_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadIn,
  input  logic       cfgN,
  output xbar_strb_t strb,
  output logic       ready
);

  logic loadS, cfgS;
  logic loadPrev, cfgPrev;
  logic loadRise, loadFall, cfgRise, cfgFall;

  // Load idles low and configure idles high; reset values match the idle levels
  xbar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uLoadSync (
    .clk(clk), .rstN(rstN), .asyncIn(loadIn), .syncOut(loadS)
  );
  xbar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uCfgSync (
    .clk(clk), .rstN(rstN), .asyncIn(cfgN), .syncOut(cfgS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPrev <= 1'b0;
      cfgPrev  <= 1'b1;
    end else begin
      loadPrev <= loadS;
      cfgPrev  <= cfgS;
    end
  end

  always_comb begin
    loadRise = ~loadPrev &  loadS;
    loadFall =  loadPrev & ~loadS;
    cfgRise  = ~cfgPrev  &  cfgS;
    cfgFall  =  cfgPrev  & ~cfgS;
  end

  always_comb begin
    strb.portWr   = loadFall;
    strb.cfgXfer  = cfgFall;
    strb.readyClr = loadRise | cfgFall;
    strb.readySet = cfgRise;
  end

  // Clearing wins over setting when both are seen in one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ready <= 1'b0;
    else if (strb.readyClr) ready <= 1'b0;
    else if (strb.readySet) ready <= 1'b1;
  end

endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter  int NUM_PORTS = 16,
  parameter  int DATA_W    = 1,
  localparam int SEL_W     = $clog2(NUM_PORTS),
  localparam int BUS_W     = NUM_PORTS * DATA_W,
  localparam int MAP_W     = NUM_PORTS * SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  xbar_strb_t       strb,
  input  logic [SEL_W-1:0] srcAddr,
  input  logic [SEL_W-1:0] dstAddr,
  input  logic             bulkWr,
  input  logic [MAP_W-1:0] bulkSel,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic [MAP_W-1:0] pendingFlat,
  output logic [MAP_W-1:0] activeFlat
);

  logic [SEL_W-1:0] pendBank [NUM_PORTS];
  logic [SEL_W-1:0] pendNext [NUM_PORTS];
  logic [SEL_W-1:0] activeSel[NUM_PORTS];

  // Bulk load first, then the single-port write overlays its destination
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      pendNext[p] = bulkWr ? bulkSel[p*SEL_W +: SEL_W] : pendBank[p];
    end
    if (strb.portWr) pendNext[dstAddr] = srcAddr;
  end

  // Pending bank has no reset so the user map outlives a reset pulse
  always_ff @(posedge clk) begin
    if (bulkWr || strb.portWr) begin
      for (int p = 0; p < NUM_PORTS; p++) pendBank[p] <= pendNext[p];
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gOut
    // A selector is loaded only when its value changes, so untouched paths stay quiet
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        activeSel[g] <= '0;
      else if (strb.cfgXfer && (pendNext[g] != activeSel[g]))
        activeSel[g] <= pendNext[g];
    end

    assign dataOut[g*DATA_W +: DATA_W]    = dataIn[activeSel[g]*DATA_W +: DATA_W];
    assign pendingFlat[g*SEL_W +: SEL_W]  = pendBank[g];
    assign activeFlat[g*SEL_W +: SEL_W]   = activeSel[g];
  end

endmodule

// File: rtl/xpoint_switch.sv
module xpoint_switch
  import xbar_pkg::*;
#(
  parameter  int NUM_PORTS = 16,
  parameter  int DATA_W    = 1,
  localparam int SEL_W     = $clog2(NUM_PORTS),
  localparam int BUS_W     = NUM_PORTS * DATA_W,
  localparam int MAP_W     = NUM_PORTS * SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadIn,
  input  logic [SEL_W-1:0] srcAddr,
  input  logic [SEL_W-1:0] dstAddr,
  input  logic             cfgN,
  input  logic             bulkWr,
  input  logic [MAP_W-1:0] bulkSel,
  input  logic [BUS_W-1:0] dataIn,
  output logic [BUS_W-1:0] dataOut,
  output logic             ready
);

  xbar_strb_t       strb;
  logic [MAP_W-1:0] pendingFlat;
  logic [MAP_W-1:0] activeFlat;

  xbar_ctrl #(.SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .cfgN(cfgN),
    .strb(strb), .ready(ready)
  );

  xbar_datapath #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcAddr(srcAddr), .dstAddr(dstAddr),
    .bulkWr(bulkWr), .bulkSel(bulkSel),
    .dataIn(dataIn), .dataOut(dataOut),
    .pendingFlat(pendingFlat), .activeFlat(activeFlat)
  );

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
#(
  parameter  int NUM_PORTS = 16,
  parameter  int DATA_W    = 1,
  localparam int SEL_W     = $clog2(NUM_PORTS),
  localparam int BUS_W     = NUM_PORTS * DATA_W,
  localparam int MAP_W     = NUM_PORTS * SEL_W
) (
  input logic             clk,
  input logic             rstN,
  input xbar_strb_t       strb,
  input logic             bulkWr,
  input logic             ready,
  input logic [MAP_W-1:0] pendingFlat,
  input logic [MAP_W-1:0] activeFlat,
  input logic [BUS_W-1:0] dataIn,
  input logic [BUS_W-1:0] dataOut
);

  // R6
  reset_route_chk: assert property (@(posedge clk)
    !rstN |-> dataOut == {NUM_PORTS{dataIn[DATA_W-1:0]}});

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgXfer |=> $stable(activeFlat));

  // R4
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgXfer |=> activeFlat == pendingFlat);

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.portWr && !bulkWr |=> $stable(pendingFlat));

  // R9
  ready_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.readyClr |=> !ready);

  // R9
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.readySet && !strb.readyClr |=> ready);

endmodule

bind xpoint_switch xbar_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .bulkWr(bulkWr), .ready(ready),
  .pendingFlat(pendingFlat), .activeFlat(activeFlat),
  .dataIn(dataIn), .dataOut(dataOut)
);

// File: tb/tb_xpoint_switch.sv
module tb_xpoint_switch;
  localparam int NP = 16;
  localparam int DW = 1;
  localparam int SW = 4;
  localparam int BW = NP * DW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rstN, loadIn, cfgN, bulkWr, ready;
  logic [SW-1:0]   srcAddr, dstAddr;
  logic [NP*SW-1:0] bulkSel;
  logic [BW-1:0]   dataIn, dataOut;

  xpoint_switch #(.NUM_PORTS(NP), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .cfgN(cfgN), .bulkWr(bulkWr), .bulkSel(bulkSel),
    .dataIn(dataIn), .dataOut(dataOut), .ready(ready)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [SW-1:0] expPend[NP];
  logic [SW-1:0] expAct [NP];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [BW-1:0] routeOf(input logic [BW-1:0] din, input bit toZero);
    logic [BW-1:0] r;
    for (int p = 0; p < NP; p++)
      r[p*DW +: DW] = din[(toZero ? 0 : int'(expAct[p]))*DW +: DW];
    return r;
  endfunction

  task automatic checkRoutes(input string req, input bit toZero);
    logic [BW-1:0] e;
    dataIn = BW'($urandom);
    #1;
    e = routeOf(dataIn, toZero);
    check(dataOut === e, req, 64'(dataOut), 64'(e));
  endtask

  // R2: single-port write; R9: load rise clears ready; R10: no output change
  task automatic portWrite(input logic [SW-1:0] src, input logic [SW-1:0] dst);
    srcAddr = src; dstAddr = dst; loadIn = 1'b1;
    tick(3);
    check(ready === 1'b0, "R9 load rise clears ready", 64'(ready), 64'd0);
    loadIn = 1'b0;
    tick(3);
    expPend[dst] = src;
    checkRoutes("R10 pending write leaves outputs", 1'b0);
  endtask

  task automatic bulkWrite(input logic [NP*SW-1:0] v);
    bulkSel = v; bulkWr = 1'b1;
    tick(1);
    bulkWr = 1'b0;
    for (int p = 0; p < NP; p++) expPend[p] = v[p*SW +: SW];
    checkRoutes("R10 bulk write leaves outputs", 1'b0);
  endtask

  // R4 latency, R8 unchanged paths, R9 ready low then high
  task automatic configure();
    logic [BW-1:0] keepMask, e;
    keepMask = '0;
    for (int p = 0; p < NP; p++)
      if (expPend[p] == expAct[p]) keepMask[p*DW +: DW] = '1;
    cfgN = 1'b0;
    tick(2);
    checkRoutes("R4 active not yet changed", 1'b0);
    @(posedge clk); #1;
    e = routeOf(dataIn, 1'b0);
    check((dataOut & keepMask) === (e & keepMask), "R8 unchanged paths hold",
          64'(dataOut & keepMask), 64'(e & keepMask));
    @(negedge clk);
    for (int p = 0; p < NP; p++) expAct[p] = expPend[p];
    checkRoutes("R4 active updated", 1'b0);
    check(ready === 1'b0, "R9 configure fall clears ready", 64'(ready), 64'd0);
    cfgN = 1'b1;
    tick(2);
    check(ready === 1'b0, "R9 ready not early", 64'(ready), 64'd0);
    tick(1);
    check(ready === 1'b1, "R9 configure rise sets ready", 64'(ready), 64'd1);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [NP*SW-1:0] v;
    logic [SW-1:0] s, d;
    void'($urandom(32'd2024));
    rstN = 1'b0; loadIn = 1'b0; cfgN = 1'b1; bulkWr = 1'b0;
    srcAddr = '0; dstAddr = '0; bulkSel = '0; dataIn = '0;
    for (int p = 0; p < NP; p++) begin expPend[p] = '0; expAct[p] = '0; end
    tick(1);
    checkRoutes("R6 reset routes input 0", 1'b1);
    check(ready === 1'b0, "R9 ready low in reset", 64'(ready), 64'd0);
    tick(2);
    rstN = 1'b1;
    tick(2);

    // R3 bit order: output n takes input 15-n
    for (int p = 0; p < NP; p++) v[p*SW +: SW] = SW'(NP - 1 - p);
    bulkWrite(v);
    configure();
    dataIn = BW'(1); #1;
    check(dataOut === BW'(1 << (NP - 1)), "R3 bulk field order", 64'(dataOut),
          64'(1 << (NP - 1)));

    // R1 fan-out: all outputs on input 5
    bulkWrite({NP{4'd5}});
    configure();
    dataIn = BW'(1 << 5); #1;
    check(dataOut === '1, "R1 fan-out of one input", 64'(dataOut), 64'hffff);
    tick(1);

    // R2 single-port writes
    portWrite(4'd9, 4'd2);
    portWrite(4'd14, 4'd11);
    configure();
    checkRoutes("R2 single-port routing", 1'b0);

    // R3 same-edge bulk and single-port write: single-port wins
    srcAddr = 4'd7; dstAddr = 4'd3; loadIn = 1'b1;
    tick(3);
    loadIn = 1'b0;
    tick(2);
    v = {$urandom, $urandom};
    bulkSel = v; bulkWr = 1'b1;
    tick(1);
    bulkWr = 1'b0;
    for (int p = 0; p < NP; p++) expPend[p] = v[p*SW +: SW];
    expPend[3] = 4'd7;
    configure();
    checkRoutes("R3 single-port overrides bulk", 1'b0);

    // R5 write and configure on the same edge
    srcAddr = 4'd12; dstAddr = 4'd0; loadIn = 1'b1;
    tick(3);
    loadIn = 1'b0; cfgN = 1'b0;
    tick(3);
    expPend[0] = 4'd12;
    for (int p = 0; p < NP; p++) expAct[p] = expPend[p];
    checkRoutes("R5 write joins transfer", 1'b0);
    cfgN = 1'b1;
    tick(3);

    // R7 pending survives reset
    portWrite(4'd1, 4'd15);
    rstN = 1'b0;
    checkRoutes("R6 async reset routes input 0", 1'b1);
    tick(2);
    rstN = 1'b1;
    for (int p = 0; p < NP; p++) expAct[p] = '0;
    tick(2);
    checkRoutes("R7 default routing after reset", 1'b1);
    configure();
    checkRoutes("R7 user routing restored", 1'b0);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 3)
        0: begin s = SW'($urandom); d = SW'($urandom); portWrite(s, d); end
        1: bulkWrite({$urandom, $urandom});
        default: begin configure(); checkRoutes("R1 random routing", 1'b0); end
      endcase
    end
    configure();
    checkRoutes("R1 final routing", 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule